// File: doc/BRIEF.md
# Z80 Memory Read Wait-State Generator

This block sits between a Z80 bus and a memory port whose read latency is not fixed. It watches the processor's memory-request, read and fetch strobes through a synchroniser and sees each memory read. For every read it sends the captured 16-bit address to the memory port as one request, then waits for a response strobe. The returned byte is latched and driven onto the processor data bus for as long as the read strobe stays low.

WAIT is pulled low only when a response is slow. Each read type has its own grace period of 0 to 4 command clocks, counted from detection. A response that arrives inside that period causes no wait state, so fast cache hits run at full speed. A setting of 0 gives a wait state on every read of that type. When the response arrives, WAIT is released in one of two ways, chosen by a parameter. In the first, it is released on the same clock edge. In the second, it is released only while the synchronised processor clock is low.

If the processor drops a cycle before its data arrives, the block goes back to idle and discards the response that was still outstanding. That late data therefore never reaches a later read.

Top module: `z80_wait_gen`

## Requirements
- R1: While reset is held and after it is released with the bus idle, wait_n_o is 1, req_valid_o is 0 and data_oe_o is 0.
- R2: A memory read is taken as mreq_n_i and rd_n_i both low after a two-stage synchroniser. The request first shows on req_valid_o after the third clock edge after both inputs went low. This edge is called the detection edge.
- R3: Each read cycle issues exactly one request, carrying the address present at detection. req_valid_o and req_addr_o hold steady until a clock edge on which req_ready_i is 1.
- R4: With m1_n_i low at detection, the read is a fetch with grace DLY_M1 (default 0). Otherwise it is a memory read with grace DLY_MEM (default 3). If rsp_valid_i has not been sampled high by the edge d edges after the detection edge, wait_n_o is 0 after that edge, where d is the grace.
- R5: A grace of 0 drives wait_n_o low right after the detection edge on every read of that type, however fast the response is.
- R6: If rsp_valid_i is sampled high on or before the edge d edges after detection, wait_n_o stays 1 for the whole cycle.
- R7: With QUICK_OFF = 1, wait_n_o returns to 1 right after the edge on which rsp_valid_i is sampled.
- R8: With QUICK_OFF = 0, wait_n_o returns to 1 one edge after the response edge if the synchronised z80_clk_i is low. Otherwise it stays 0 until an edge that sees the synchronised clock low.
- R9: rsp_data_i is latched on the response edge. It is driven on data_o with data_oe_o = 1 while the synchronised rd_n_i is low. data_oe_o falls once rd_n_i is seen high, and the block goes idle when mreq_n_i is seen high.
- R10: If mreq_n_i or rd_n_i goes high before the response, the block goes idle with wait_n_o = 1. The next rsp_valid_i pulse belongs to the dropped request: it is discarded, whether it comes while idle or during a later read, and that later read presents only its own data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| z80_clk_i | input | 1 | Processor clock, sampled for WAIT release |
| mreq_n_i | input | 1 | Memory request strobe, active low |
| rd_n_i | input | 1 | Read strobe, active low |
| m1_n_i | input | 1 | Opcode fetch marker, active low |
| addr_i | input | AW (16) | Processor address bus |
| data_o | output | DW (8) | Read data toward the processor |
| data_oe_o | output | 1 | Enable for driving data_o onto the bus |
| wait_n_o | output | 1 | WAIT, 0 inserts wait states (open-drain drive level) |
| req_valid_o | output | 1 | Read request to memory |
| req_addr_o | output | AW (16) | Read request address |
| req_ready_i | input | 1 | Memory accepts the request |
| rsp_valid_i | input | 1 | Read data ready, single-cycle pulse |
| rsp_data_i | input | DW (8) | Read data from memory |

## Verification
Reads are driven with a random mix of fetch and memory types, with request-accept delays of 0 to 2 clocks and response latencies of 1 to 6 clocks. This places the response before, exactly at, and after the grace limit of each type. The number of clocks with WAIT low is compared between a delayed-release instance and an instant-release instance, and each is checked against its own expected count. Holding the processor clock high after the data arrives separates the two release rules. Aborted reads are followed by a late response either while idle or inside the next read, which shows whether stale data is kept apart from fresh data.

// File: rtl/z80wg_pkg.sv
package z80wg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_DATA = 2'd2,
    ST_DONE = 2'd3
  } rd_state_e;
endpackage

// File: rtl/z80wg_rst_sync.sv
module z80wg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] stg_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= 2'b00;
    else        stg_q <= {stg_q[0], 1'b1};
  end
  assign rst_sn = stg_q[1];
endmodule

// File: rtl/z80wg_sync.sv
module z80wg_sync #(
  parameter int         W       = 4,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= RST_VAL;
        else        stg_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= RST_VAL;
        else        stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/z80wg_ctrl.sv
module z80wg_ctrl
  import z80wg_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mreq_s,
  input  logic          rd_s,
  input  logic [AW-1:0] addr_i,
  output logic          req_valid_o,
  output logic [AW-1:0] req_addr_o,
  input  logic          req_ready_i,
  input  logic          rsp_valid_i,
  input  logic [DW-1:0] rsp_data_i,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o,
  output logic          start_o,
  output logic          pend_o,
  output logic          hit_o,
  output logic          done_o
);
  rd_state_e     st_q, st_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] dat_q, dat_d;
  logic          stale_q, stale_d;
  logic          rd_act, fresh_rsp;

  assign rd_act    = !mreq_s && !rd_s;
  assign fresh_rsp = rsp_valid_i && !stale_q;

  always_comb begin
    st_d    = st_q;
    addr_d  = addr_q;
    dat_d   = dat_q;
    stale_d = stale_q;
    start_o = 1'b0;
    hit_o   = 1'b0;
    if (stale_q && rsp_valid_i) stale_d = 1'b0;
    unique case (st_q)
      ST_IDLE: if (rd_act) begin
        st_d    = ST_REQ;
        addr_d  = addr_i;
        start_o = 1'b1;
      end
      ST_REQ: begin
        if (!rd_act)          st_d = ST_IDLE;
        else if (req_ready_i) st_d = ST_DATA;
      end
      ST_DATA: begin
        if (!rd_act) begin
          st_d = ST_IDLE;
          if (!fresh_rsp) stale_d = 1'b1;
        end else if (fresh_rsp) begin
          st_d  = ST_DONE;
          dat_d = rsp_data_i;
          hit_o = 1'b1;
        end
      end
      ST_DONE: if (mreq_s) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      dat_q   <= '0;
      stale_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      stale_q <= stale_d;
      if (start_o) addr_q <= addr_d;
      if (hit_o)   dat_q  <= dat_d;
    end
  end

  assign pend_o      = (st_q == ST_REQ || st_q == ST_DATA) && rd_act && !hit_o;
  assign done_o      = (st_q == ST_DONE);
  assign req_valid_o = (st_q == ST_REQ);
  assign req_addr_o  = addr_q;
  assign data_o      = dat_q;
  assign data_oe_o   = done_o && !rd_s;
endmodule

// File: rtl/z80wg_wait.sv
module z80wg_wait #(
  parameter int DLY_M1    = 0,
  parameter int DLY_MEM   = 3,
  parameter bit QUICK_OFF = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic m1_s,
  input  logic zclk_s,
  input  logic start_i,
  input  logic pend_i,
  input  logic hit_i,
  input  logic done_i,
  output logic wait_n_o
);
  localparam int DMAX = (DLY_M1 > DLY_MEM) ? DLY_M1 : DLY_MEM;
  localparam int CW   = $clog2(DMAX + 2);
  localparam logic [CW-1:0] D_M1  = CW'(DLY_M1);
  localparam logic [CW-1:0] D_MEM = CW'(DLY_MEM);
  localparam logic [CW-1:0] D_TOP = CW'(DMAX);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          fetch_q, fetch_d;
  logic          wait_q, wait_d;
  logic [CW-1:0] dly_start, dly_cur;

  assign dly_start = !m1_s   ? D_M1 : D_MEM;
  assign dly_cur   = fetch_q ? D_M1 : D_MEM;

  always_comb begin
    cnt_d   = cnt_q;
    fetch_d = fetch_q;
    wait_d  = 1'b0;
    if (start_i) begin
      cnt_d   = '0;
      fetch_d = !m1_s;
      wait_d  = (dly_start == '0);
    end else if (pend_i) begin
      cnt_d  = (cnt_q == D_TOP) ? cnt_q : cnt_q + 1'b1;
      wait_d = (cnt_d >= dly_cur);
    end else if (hit_i) begin
      wait_d = QUICK_OFF ? 1'b0 : wait_q;
    end else if (done_i) begin
      wait_d = QUICK_OFF ? 1'b0 : (wait_q && zclk_s);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      fetch_q <= 1'b0;
      wait_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      wait_q <= wait_d;
      if (start_i) fetch_q <= fetch_d;
    end
  end

  assign wait_n_o = !wait_q;
endmodule

// File: rtl/z80_wait_gen.sv
module z80_wait_gen #(
  parameter int AW          = 16,
  parameter int DW          = 8,
  parameter int DLY_M1      = 0,
  parameter int DLY_MEM     = 3,
  parameter bit QUICK_OFF   = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          z80_clk_i,
  input  logic          mreq_n_i,
  input  logic          rd_n_i,
  input  logic          m1_n_i,
  input  logic [AW-1:0] addr_i,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o,
  output logic          wait_n_o,
  output logic          req_valid_o,
  output logic [AW-1:0] req_addr_o,
  input  logic          req_ready_i,
  input  logic          rsp_valid_i,
  input  logic [DW-1:0] rsp_data_i
);
  localparam int NSYNC = 4;

  logic             rst_sn;
  logic [NSYNC-1:0] sync_in, sync_out;
  logic             mreq_s, rd_s, m1_s, zclk_s;
  logic             start_w, pend_w, hit_w, done_w;

  z80wg_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sn(rst_sn));

  assign sync_in = {z80_clk_i, m1_n_i, rd_n_i, mreq_n_i};

  z80wg_sync #(.W(NSYNC), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk(clk), .rst_n(rst_sn), .d_i(sync_in), .q_o(sync_out)
  );

  assign mreq_s = sync_out[0];
  assign rd_s   = sync_out[1];
  assign m1_s   = sync_out[2];
  assign zclk_s = sync_out[3];

  z80wg_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk(clk), .rst_n(rst_sn), .mreq_s(mreq_s), .rd_s(rd_s), .addr_i(addr_i),
    .req_valid_o(req_valid_o), .req_addr_o(req_addr_o), .req_ready_i(req_ready_i),
    .rsp_valid_i(rsp_valid_i), .rsp_data_i(rsp_data_i),
    .data_o(data_o), .data_oe_o(data_oe_o),
    .start_o(start_w), .pend_o(pend_w), .hit_o(hit_w), .done_o(done_w)
  );

  z80wg_wait #(.DLY_M1(DLY_M1), .DLY_MEM(DLY_MEM), .QUICK_OFF(QUICK_OFF)) u_wait (
    .clk(clk), .rst_n(rst_sn), .m1_s(m1_s), .zclk_s(zclk_s),
    .start_i(start_w), .pend_i(pend_w), .hit_i(hit_w), .done_i(done_w),
    .wait_n_o(wait_n_o)
  );
endmodule

// File: rtl/z80wg_checker.sv
module z80wg_checker #(
  parameter int AW        = 16,
  parameter bit QUICK_OFF = 1'b0
) (
  input logic          clk,
  input logic          rst_sn,
  input logic          mreq_s,
  input logic          rd_s,
  input logic          zclk_s,
  input logic          req_valid_o,
  input logic          req_ready_i,
  input logic [AW-1:0] req_addr_o,
  input logic          wait_n_o,
  input logic          start_w,
  input logic          pend_w,
  input logic          done_w
);
  // R3: a request is taken once
  a_r3_single_request: assert property (@(posedge clk) disable iff (!rst_sn)
    (req_valid_o && req_ready_i) |=> !req_valid_o);

  // R3: an unaccepted request stays put while the read lasts
  a_r3_request_held: assert property (@(posedge clk) disable iff (!rst_sn)
    (req_valid_o && !req_ready_i && !mreq_s && !rd_s) |=> (req_valid_o && $stable(req_addr_o)));

  // R4: WAIT only falls while a read is still waiting for data
  a_r4_wait_only_pending: assert property (@(posedge clk) disable iff (!rst_sn)
    $fell(wait_n_o) |-> ($past(pend_w) || $past(start_w)));

  // R7: instant release never leaves WAIT low once data is held
  a_r7_quick_release: assert property (@(posedge clk) disable iff (!rst_sn)
    (QUICK_OFF && done_w) |-> wait_n_o);

  // R8: delayed release happens only on a low processor clock
  a_r8_release_on_low: assert property (@(posedge clk) disable iff (!rst_sn)
    (!QUICK_OFF && done_w && $past(done_w) && $rose(wait_n_o)) |-> !$past(zclk_s));
endmodule

bind z80_wait_gen z80wg_checker #(.AW(AW), .QUICK_OFF(QUICK_OFF)) u_chk (
  .clk(clk), .rst_sn(rst_sn), .mreq_s(mreq_s), .rd_s(rd_s), .zclk_s(zclk_s),
  .req_valid_o(req_valid_o), .req_ready_i(req_ready_i), .req_addr_o(req_addr_o),
  .wait_n_o(wait_n_o), .start_w(start_w), .pend_w(pend_w), .done_w(done_w)
);

// File: tb/tb_z80_wait_gen.sv
module tb_z80_wait_gen;
  localparam int CLK_PERIOD = 10;
  localparam int D_FETCH = 0;
  localparam int D_MEM   = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        zclk = 1'b0, mreq_n = 1'b1, rd_n = 1'b1, m1_n = 1'b1;
  logic [15:0] addr = '0;
  logic        ready = 1'b0, rsp_v = 1'b0;
  logic [7:0]  rsp_d = '0;

  logic [7:0]  dat_s, dat_f;
  logic        oe_s, oe_f, wn_s, wn_f, rv_s, rv_f;
  logic [15:0] ra_s, ra_f;

  int tests = 0, fails = 0, cycles = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  z80_wait_gen #(.DLY_M1(D_FETCH), .DLY_MEM(D_MEM), .QUICK_OFF(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .z80_clk_i(zclk), .mreq_n_i(mreq_n), .rd_n_i(rd_n),
    .m1_n_i(m1_n), .addr_i(addr), .data_o(dat_s), .data_oe_o(oe_s), .wait_n_o(wn_s),
    .req_valid_o(rv_s), .req_addr_o(ra_s), .req_ready_i(ready),
    .rsp_valid_i(rsp_v), .rsp_data_i(rsp_d));

  z80_wait_gen #(.DLY_M1(D_FETCH), .DLY_MEM(D_MEM), .QUICK_OFF(1'b1)) dut_fast (
    .clk(clk), .rst_n(rst_n), .z80_clk_i(zclk), .mreq_n_i(mreq_n), .rd_n_i(rd_n),
    .m1_n_i(m1_n), .addr_i(addr), .data_o(dat_f), .data_oe_o(oe_f), .wait_n_o(wn_f),
    .req_valid_o(rv_f), .req_addr_o(ra_f), .req_ready_i(ready),
    .rsp_valid_i(rsp_v), .rsp_data_i(rsp_d));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_fast(input int e, input int d);
    return (e - 3 - d > 0) ? e - 3 - d : 0;
  endfunction

  function automatic int exp_slow(input int e, input int d, input bit zhi);
    if (e - 3 - d <= 0) return 0;
    return zhi ? e + 3 - d : e - 2 - d;
  endfunction

  task automatic go_idle();
    @(negedge clk);
    mreq_n = 1'b1; rd_n = 1'b1; m1_n = 1'b1; zclk = 1'b0;
    ready = 1'b0; rsp_v = 1'b0;
    repeat (4) @(negedge clk);
    chk(!oe_s && !oe_f, "R9 bus released", oe_s, 0);
    chk(wn_s && wn_f, "R9 wait idle", wn_s, 1);
    chk(!rv_s, "R9 no request idle", rv_s, 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic do_read(input bit fetch, input logic [15:0] a, input int k,
                         input int lat, input bit zhi, input bit junk,
                         input logic [7:0] dv);
    int d, e, reqs, wslow, wfast;
    bit addr_ok, held_ok;
    d = fetch ? D_FETCH : D_MEM;
    e = 4 + k + lat;
    reqs = 0; wslow = 0; wfast = 0; addr_ok = 1'b1; held_ok = 1'b1;
    @(negedge clk);
    m1_n = !fetch; addr = a; mreq_n = 1'b0; rd_n = 1'b0; zclk = zhi;
    for (int n = 1; n <= e + 10; n++) begin
      @(posedge clk);
      @(negedge clk);
      if (!wn_s) wslow++;
      if (!wn_f) wfast++;
      if (n >= 3 && n <= 3 + k && !rv_s) held_ok = 1'b0;
      if (n < 3 && rv_s) held_ok = 1'b0;
      if (n == e + 1) begin
        chk(oe_s && dat_s == dv, "R9 data slow", int'(dat_s), int'(dv));
        chk(oe_f && dat_f == dv, "R9 data fast", int'(dat_f), int'(dv));
      end
      ready = (n == 3 + k);
      rsp_v = (n == e - 1) || (junk && n == e - 3);
      rsp_d = (n == e - 1) ? dv : ~dv;
      if (rv_s && ready) begin
        reqs++;
        if (ra_s != a) addr_ok = 1'b0;
      end
      if (zhi && n == e + 3) zclk = 1'b0;
    end
    chk(reqs == 1, "R3 one request", reqs, 1);
    chk(addr_ok, "R3 request address", int'(ra_s), int'(a));
    chk(held_ok, "R2 R3 request timing", int'(held_ok), 1);
    chk(wfast == exp_fast(e, d), fetch ? "R5 R7 fetch wait fast" : "R4 R6 R7 mem wait fast",
        wfast, exp_fast(e, d));
    chk(wslow == exp_slow(e, d, zhi), fetch ? "R5 R8 fetch wait slow" : "R4 R6 R8 mem wait slow",
        wslow, exp_slow(e, d, zhi));
    go_idle();
  endtask

  task automatic abort_read(input bit late_idle);
    @(negedge clk);
    m1_n = 1'b1; addr = 16'h1234; mreq_n = 1'b0; rd_n = 1'b0; zclk = 1'b0;
    for (int n = 1; n <= 5; n++) begin
      @(posedge clk);
      @(negedge clk);
      ready = (n == 3);
    end
    mreq_n = 1'b1; rd_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(wn_s && wn_f, "R10 abort wait released", wn_s, 1);
    chk(!oe_s && !rv_s, "R10 abort idle", oe_s, 0);
    if (late_idle) begin
      rsp_v = 1'b1; rsp_d = 8'hEE;
      @(negedge clk);
      rsp_v = 1'b0;
      @(negedge clk);
      chk(!oe_s && wn_s, "R10 late response ignored", oe_s, 0);
    end
  endtask

  initial begin
    void'($urandom(32'd5150));
    #(CLK_PERIOD * 3 + 1);
    chk(wn_s && !rv_s && !oe_s, "R1 in reset", wn_s, 1);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(wn_s && wn_f && !rv_s && !oe_s && !oe_f, "R1 after reset", rv_s, 0);

    // directed corner cases around the memory grace limit
    do_read(1'b0, 16'h0100, 0, 2, 1'b0, 1'b0, 8'h11); // R6 boundary: no wait
    do_read(1'b0, 16'h0200, 0, 3, 1'b0, 1'b0, 8'h22); // R4 one past boundary
    do_read(1'b1, 16'h0300, 0, 1, 1'b0, 1'b0, 8'h33); // R5 zero grace fetch
    do_read(1'b0, 16'h0400, 2, 4, 1'b1, 1'b0, 8'h44); // R8 clock held high
    do_read(1'b1, 16'h0500, 1, 2, 1'b1, 1'b0, 8'h55); // R8 fetch with high clock
    // R10: aborted cycles with stale response
    abort_read(1'b0);
    do_read(1'b0, 16'h0600, 0, 4, 1'b0, 1'b1, 8'h66);
    abort_read(1'b1);
    do_read(1'b0, 16'h0700, 0, 2, 1'b0, 1'b0, 8'h77);

    for (int i = 0; i < 40; i++) begin
      do_read(1'($urandom % 2), 16'($urandom), int'($urandom % 3),
              1 + int'($urandom % 6), ($urandom % 4) == 0, 1'b0, 8'($urandom));
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule